// File: doc/BRIEF.md
# Selectable PRBS Pattern Generator

This block produces a pseudo-random binary test pattern for the transmit side of a JESD204B link. Every enabled clock it delivers a fresh 64-bit word, which is the next 64 bits of the chosen sequence. A two-bit select input picks one of four maximal-length sequences: PRBS7, PRBS15, PRBS23 or PRBS31. A downstream receiver checker can lock to the stream and count bit errors.

To show that such a checker really detects errors, a one-cycle error request inverts a single bit of one outgoing word. The sequence generator itself is left untouched, so the stream stays aligned and every later word is clean. When the enable input is low, the generator freezes and its output word holds. Changing the select restarts the new sequence from an all-ones seed.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `data_out` to zero and drops `data_vld`. It loads the generator with all ones across the width of the selected sequence. The sequence named by `pat_sel` at that edge becomes the active one.
- R2: `pat_sel` = 0 selects PRBS7, generated with x^7+x^6+1. From the seed, each produced bit is the XOR of register stages 7 and 6, and that bit is then shifted into stage 1.
- R3: `pat_sel` = 1 selects PRBS15, generated with x^15+x^14+1 (stages 15 and 14).
- R4: `pat_sel` = 2 selects PRBS23, generated with x^23+x^18+1 (stages 23 and 18).
- R5: `pat_sel` = 3 selects PRBS31, generated with x^31+x^28+1 (stages 31 and 28).
- R6: A rising edge at which `pat_sel` differs from the active sequence reseeds the generator with all ones for the new length. At that edge `data_vld` goes low and `data_out` holds. The next enabled word is the first word of the new sequence.
- R7: `err_inj` high at an edge that produces a word inverts bit 0 of that word, and only bit 0. The generator state is unaffected, so the following word equals the error-free sequence.
- R8: With `en` low, `data_out` holds, `data_vld` is low and the generator state holds. When `en` returns high, the sequence continues from the word after the last one produced. At each edge with `en` high and no select change, a new word appears with `data_vld` high.
- R9: An `err_inj` pulse at an edge that produces no word (because `en` is low or a reseed occurs) is remembered. It is applied to bit 0 of the next produced word, and to that word only.
- R10: Bit 63 of each word holds the earliest bit of the 64 and bit 0 the latest. The first PRBS7 word after the seed therefore starts, from bit 63 down to bit 57, with 0000001.
- R11: The PRBS7 output repeats with a period of 127 words, because 64 x 127 bits is a whole number of 127-bit periods.
- R12: The generator never enters the all-zero state, so no word of PRBS7 is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable; low freezes the generator |
| pat_sel | input | 2 | Sequence select: 0 PRBS7, 1 PRBS15, 2 PRBS23, 3 PRBS31 |
| err_inj | input | 1 | One-cycle request to invert bit 0 of the next produced word |
| data_out | output | 64 | Pattern word, earliest bit in bit 63 |
| data_vld | output | 1 | High for a cycle when `data_out` carries a newly produced word |

## Verification
The checker module watches the control behaviour on every cycle:
- `data_out` holds and `data_vld` stays low when idle or on a select change.
- The all-ones seed is loaded on a reseed.
- The generator state stays nonzero.
- The state tracks the word just produced in every bit except bit 0, so an inserted error cannot leak into it.
- The pending-error flag is set and cleared correctly.

Only the bench's scenarios can show that the bit values themselves are right. It compares each word against a bit-serial model of each polynomial, checks the MSB-first ordering, the 127-word period of PRBS7, and that exactly one bit of exactly one word is corrupted.

// File: rtl/prbs_pkg.sv
// Package: shared types and per-length constants for the PRBS generator.
// Assumes the longest sequence needs no more than PRBS_MAX_DEG stages.
package prbs_pkg;

    localparam int PRBS_MAX_DEG = 31;
    localparam int PRBS_NUM_LEN = 4;

    typedef enum logic [1:0] {
        PAT_P7  = 2'd0,
        PAT_P15 = 2'd1,
        PAT_P23 = 2'd2,
        PAT_P31 = 2'd3
    } pat_sel_e;

    // Register length (polynomial degree) for each select code.
    function automatic int deg_of(input int idx);
        case (idx)
            0:       return 7;
            1:       return 15;
            2:       return 23;
            default: return 31;
        endcase
    endfunction

    // Second feedback stage (middle term of the trinomial) for each select code.
    function automatic int tap_of(input int idx);
        case (idx)
            0:       return 6;
            1:       return 14;
            2:       return 18;
            default: return 28;
        endcase
    endfunction

    // All-ones mask that covers the stages used by one sequence length.
    function automatic logic [PRBS_MAX_DEG-1:0] seed_mask(input pat_sel_e sel);
        logic [PRBS_MAX_DEG-1:0] m;
        m = '0;
        for (int i = 0; i < PRBS_MAX_DEG; i++) begin
            if (i < deg_of(int'(sel))) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/prbs_unroll.sv
// Module: prbs_unroll
// Purely combinational. It computes the next W output bits of one Fibonacci
// LFSR with the trinomial x^DEG + x^TAP + 1, starting from the given state.
// The earliest bit goes to word[W-1]. Assumes W >= DEG, so the state after W
// steps equals word[DEG-1:0] and the caller can take it from the word.
module prbs_unroll #(
    parameter int DEG = 7,
    parameter int TAP = 6,
    parameter int W   = 64
) (
    input  logic [DEG-1:0] state_in,
    output logic [W-1:0]   word
);

    // Step the register W times, recording each feedback bit MSB first.
    function automatic logic [W-1:0] run_steps(input logic [DEG-1:0] s0);
        logic [DEG-1:0] s;
        logic [W-1:0]   acc;
        logic           fb;
        s   = s0;
        acc = '0;
        for (int i = 0; i < W; i++) begin
            fb           = s[DEG-1] ^ s[TAP-1];
            acc[W-1-i]   = fb;
            s            = {s[DEG-2:0], fb};
        end
        return acc;
    endfunction

    // Whole unrolled network in one combinational cone.
    always_comb begin
        word = run_steps(state_in);
    end

endmodule

// File: rtl/prbs_core.sv
// Module: prbs_core
// Holds one shared state register and the active select. One unrolled
// network per sequence length sits on top of the register, and the active
// length picks which word leaves the block and which next state is loaded.
// A reset or a select change loads all ones for the new length; otherwise
// the state advances by W bits whenever 'advance' is high.
// Assumes W >= PRBS_MAX_DEG.
module prbs_core
    import prbs_pkg::*;
#(
    parameter int W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [1:0]              pat_sel,
    output pat_sel_e                sel_q,
    output logic [PRBS_MAX_DEG-1:0] state_q,
    output logic                    reseed,
    output logic                    advance,
    output logic [W-1:0]            word
);

    localparam int NL = PRBS_NUM_LEN;

    logic [W-1:0]            words [NL];
    logic [PRBS_MAX_DEG-1:0] next_state;

    // One unrolled network per supported sequence length.
    for (genvar g = 0; g < NL; g++) begin : g_len
        localparam int D = deg_of(g);
        localparam int T = tap_of(g);
        prbs_unroll #(.DEG(D), .TAP(T), .W(W)) u_unroll (
            .state_in (state_q[D-1:0]),
            .word     (words[g])
        );
    end

    // Decide between a reseed and an advance for this cycle.
    always_comb begin
        reseed  = (pat_sel != sel_q);
        advance = en && !reseed;
    end

    // Pick the active length's word; its low bits form the next state.
    always_comb begin
        word       = words[sel_q];
        next_state = word[PRBS_MAX_DEG-1:0] & seed_mask(sel_q);
    end

    // State and active-select register with seeding on reset or change.
    always_ff @(posedge clk) begin
        if (!rst_n || reseed) begin
            sel_q   <= pat_sel_e'(pat_sel);
            state_q <= seed_mask(pat_sel_e'(pat_sel));
        end else if (advance) begin
            state_q <= next_state;
        end
    end

endmodule

// File: rtl/prbs_out_stage.sv
// Module: prbs_out_stage
// Registers the word and its valid flag, and applies error insertion.
// An error request inverts bit 0 of the word produced at that edge. If no
// word is produced at that edge, the request is held until the next one.
// The generator state never sees the inverted bit.
module prbs_out_stage #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         advance,
    input  logic         err_inj,
    input  logic [W-1:0] word,
    output logic [W-1:0] data_out,
    output logic         data_vld,
    output logic         err_pend
);

    logic         flip;
    logic [W-1:0] err_mask;

    // Combine a live request with one left over from an idle cycle.
    always_comb begin
        flip     = err_inj || err_pend;
        err_mask = {{(W-1){1'b0}}, flip};
    end

    // Output word, valid flag and pending-error register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
            data_vld <= 1'b0;
            err_pend <= 1'b0;
        end else begin
            data_vld <= advance;
            if (advance) begin
                data_out <= word ^ err_mask;
                err_pend <= 1'b0;
            end else begin
                err_pend <= flip;
            end
        end
    end

endmodule

// File: rtl/prbs_pattern_gen.sv
// Module: prbs_pattern_gen (top)
// Selectable PRBS source that delivers W bits per enabled clock to a link
// transmitter. It joins the state/select core to the output stage.
// Assumes a synchronous active-low reset and W >= 31.
module prbs_pattern_gen
    import prbs_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [1:0]   pat_sel,
    input  logic         err_inj,
    output logic [W-1:0] data_out,
    output logic         data_vld
);

    pat_sel_e                sel_q;
    logic [PRBS_MAX_DEG-1:0] state_q;
    logic                    reseed;
    logic                    advance;
    logic [W-1:0]            word;
    logic                    err_pend;

    prbs_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .pat_sel (pat_sel),
        .sel_q   (sel_q),
        .state_q (state_q),
        .reseed  (reseed),
        .advance (advance),
        .word    (word)
    );

    prbs_out_stage #(.W(W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .err_inj  (err_inj),
        .word     (word),
        .data_out (data_out),
        .data_vld (data_vld),
        .err_pend (err_pend)
    );

endmodule

// File: rtl/prbs_pattern_gen_chk.sv
// Module: prbs_pattern_gen_chk
// Assertion checker bound to the top module. It observes the ports and the
// core's state, active select and pending-error flag.
module prbs_pattern_gen_chk
    import prbs_pkg::*;
#(
    parameter int W = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en,
    input logic [1:0]              pat_sel,
    input logic                    err_inj,
    input logic [W-1:0]            data_out,
    input logic                    data_vld,
    input pat_sel_e                sel_q,
    input logic [PRBS_MAX_DEG-1:0] state_q,
    input logic                    err_pend
);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(data_out) && !data_vld));

    p_produce_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pat_sel == sel_q) |=> data_vld);

    p_reseed_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_sel != sel_q) |=> (!data_vld && $stable(data_out)
                                && state_q == seed_mask(sel_q)));

    p_nonzero_state_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q & seed_mask(sel_q)) != '0));

    p_state_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pat_sel == sel_q) |=>
            (((state_q ^ data_out[PRBS_MAX_DEG-1:0]) & seed_mask(sel_q)
              & ~{{(PRBS_MAX_DEG-1){1'b0}}, 1'b1}) == '0));

    p_err_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_inj && !(en && pat_sel == sel_q)) |=> err_pend);

    p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pat_sel == sel_q) |=> !err_pend);

endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .pat_sel  (pat_sel),
    .err_inj  (err_inj),
    .data_out (data_out),
    .data_vld (data_vld),
    .sel_q    (sel_q),
    .state_q  (state_q),
    .err_pend (err_pend)
);

// File: tb/sim_prbs_pattern_gen.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking against a bit-serial model.
module sim_prbs_pattern_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [1:0]  pat_sel = 2'd0;
    logic        err_inj = 1'b0;
    logic [63:0] data_out;
    logic        data_vld;

    int n_chk = 0;
    int n_fail = 0;
    logic [30:0] m_st;
    int          m_deg, m_tap;

    always #2.5 clk = ~clk;

    prbs_pattern_gen u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .pat_sel(pat_sel),
        .err_inj(err_inj), .data_out(data_out), .data_vld(data_vld)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_seed(input int s);
        case (s)
            0: begin m_deg = 7;  m_tap = 6;  end
            1: begin m_deg = 15; m_tap = 14; end
            2: begin m_deg = 23; m_tap = 18; end
            default: begin m_deg = 31; m_tap = 28; end
        endcase
        m_st = '0;
        for (int i = 0; i < m_deg; i++) m_st[i] = 1'b1;
    endtask

    task automatic model_next(output logic [63:0] w);
        logic b;
        w = '0;
        for (int i = 0; i < 64; i++) begin
            b = m_st[m_deg-1] ^ m_st[m_tap-1];
            w[63-i] = b;
            m_st = {m_st[29:0], b};
            for (int k = 30; k >= 0; k--) if (k >= m_deg) m_st[k] = 1'b0;
        end
    endtask

    // Advance one enabled cycle and compare against the model.
    task automatic expect_word(input string req, input logic err);
        logic [63:0] w;
        model_next(w);
        if (err) w[0] = ~w[0];
        en = 1'b1;
        step();
        chk({req, " valid"}, {63'b0, data_vld}, 64'd1);
        chk(req, data_out, w);
    endtask

    // Put the generator at the seed of sequence s (forcing a reseed).
    task automatic fresh(input int s);
        en = 1'b0;
        err_inj = 1'b0;
        if (int'(pat_sel) == s) begin
            pat_sel = 2'((s + 1) % 4);
            step();
        end
        pat_sel = 2'(s);
        step();
        model_seed(s);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        chk("R1 valid after reset", {63'b0, data_vld}, 64'd0);
        chk("R1 data after reset", data_out, 64'd0);
        model_seed(0);
        expect_word("R1 first word from all-ones seed", 1'b0);
        en = 1'b0;
        step();
    endtask

    task automatic t_pattern(input int s, input string req);
        fresh(s);
        for (int k = 0; k < 6; k++) expect_word(req, 1'b0);
        en = 1'b0;
    endtask

    task automatic t_msb_first();
        fresh(0);
        expect_word("R2 PRBS7 word", 1'b0);
        chk("R10 earliest bits in MSB", {57'b0, data_out[63:57]}, 64'b0000001);
        en = 1'b0;
    endtask

    task automatic t_period();
        logic [63:0] w0;
        fresh(0);
        en = 1'b1;
        step();
        w0 = data_out;
        for (int k = 1; k <= 127; k++) begin
            step();
            if (data_out == 64'd0) chk("R12 no all-zero word", data_out, 64'hFFFF_FFFF_FFFF_FFFF);
        end
        chk("R12 PRBS7 words nonzero", {63'b0, (w0 != 64'd0)}, 64'd1);
        chk("R11 period of 127 words", data_out, w0);
        en = 1'b0;
    endtask

    task automatic t_reseed();
        logic [63:0] last;
        fresh(1);
        expect_word("R3 before change", 1'b0);
        expect_word("R3 before change", 1'b0);
        last = data_out;
        pat_sel = 2'd2;
        en = 1'b1;
        step();
        chk("R6 valid low on change", {63'b0, data_vld}, 64'd0);
        chk("R6 data held on change", data_out, last);
        model_seed(2);
        expect_word("R6 first word of new sequence", 1'b0);
        expect_word("R6 second word of new sequence", 1'b0);
        en = 1'b0;
    endtask

    task automatic t_err_live();
        fresh(3);
        expect_word("R5 clean", 1'b0);
        err_inj = 1'b1;
        expect_word("R7 bit 0 inverted", 1'b1);
        err_inj = 1'b0;
        expect_word("R7 next word clean", 1'b0);
        expect_word("R7 stream aligned", 1'b0);
        en = 1'b0;
    endtask

    task automatic t_hold();
        logic [63:0] last;
        fresh(2);
        expect_word("R4 before pause", 1'b0);
        last = data_out;
        en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R8 data held", data_out, last);
            chk("R8 valid low", {63'b0, data_vld}, 64'd0);
        end
        expect_word("R8 resume continues", 1'b0);
        en = 1'b0;
    endtask

    task automatic t_err_idle();
        logic [63:0] last;
        fresh(0);
        expect_word("R2 before idle error", 1'b0);
        last = data_out;
        en = 1'b0;
        err_inj = 1'b1;
        step();
        err_inj = 1'b0;
        chk("R9 idle request leaves output", data_out, last);
        step();
        chk("R9 still held", data_out, last);
        expect_word("R9 pending error applied", 1'b1);
        expect_word("R9 applied once", 1'b0);
        en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pattern(0, "R2 PRBS7");
        t_pattern(1, "R3 PRBS15");
        t_pattern(2, "R4 PRBS23");
        t_pattern(3, "R5 PRBS31");
        t_msb_first();
        t_period();
        t_reseed();
        t_err_live();
        t_hold();
        t_err_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule